// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reset Pulse

This block guards a processor against a stalled program. A prescaler chain fed by the crystal oscillator clock counts up continuously. The low part is a prescaler and the upper part is a short counter. If software fails to service the timer before the selected count is reached, the block pulls an active-low reset line for a fixed number of clock cycles. It also sets a sticky flag so that code starting after the reset can tell why the reset happened.

Software services the timer by writing to one fixed address on a simple processor bus. The written data value plays no part. A service clears the counter and every prescaler stage except the few lowest ones. This makes the worst-case service window slightly shorter than a power of two. A static configuration input chooses between a long and a short timeout. A stop-mode pulse clears the prescaler. A test-voltage indication holds the whole timer idle.

Top module: `cop_watchdog`

## Requirements
- R1: While `por_n_i` is low and on the first cycle after it rises, `rst_n_o` is 1 and `wdt_flag_o` is 0. The combined count (counter above prescaler, `PRE_W+CNT_W` bits) starts at zero.
- R2: With `rate_short_i`=0, a count that starts from zero with no service makes `rst_n_o` fall after exactly 2^(PRE_W+CNT_W) rising edges. The pulse starts when the combined count is all ones and is then advanced.
- R3: With `rate_short_i`=1, the pulse starts when the lowest `SHORT_W` bits of the combined count are all ones and the count is advanced. A change of `rate_short_i` takes effect in the same cycle and does not clear the count.
- R4: A write with `bus_wr_i`=1 and `bus_addr_i`=16'hFFFF, whatever the value of `bus_data_i`, clears the counter and prescaler bits `KEEP_W` and up. The lowest `KEEP_W` prescaler bits keep their value. Writes to any other address have no effect.
- R5: After an overflow, `rst_n_o` is low for exactly `PULSE_LEN` consecutive cycles, starting at the next edge.
- R6: The edge that starts a reset pulse also sets `wdt_flag_o` to 1.
- R7: `wdt_flag_o` stays set until `por_n_i` goes low or `flag_clr_i` is sampled high. When a set and a clear arrive in the same cycle, the set wins.
- R8: A `stop_i` pulse clears every prescaler bit and leaves the counter bits unchanged.
- R9: While `test_hv_i` is high, the combined count is held at zero and no reset pulse starts.
- R10: While the reset pulse is driven, the count is held at zero and service writes are ignored. Timing starts again from zero when the pulse ends.
- R11: The actions are ranked from highest to lowest priority: the reset pulse in progress, `test_hv_i`, a service write, `stop_i`, then overflow. A service write in the overflow cycle therefore prevents the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal oscillator clock |
| por_n_i | input | 1 | Asynchronous active-low power-on reset |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_data_i | input | 8 | Bus write data (value ignored) |
| rate_short_i | input | 1 | 1 selects the short timeout |
| stop_i | input | 1 | Stop-mode entry pulse |
| test_hv_i | input | 1 | Test-voltage indication, disables the timer |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| rst_n_o | output | 1 | Active-low reset pulse output |
| wdt_flag_o | output | 1 | Sticky watchdog-reset flag |

## Verification
The assertions check on every cycle that a low reset pulse lasts exactly the set length and that the flag rises together with it. They also check that the flag never drops without a clear, and that a service write or the test-voltage input seen while the output is high keeps it high on the next cycle. Only the bench scenarios can show the exact timeout counts in both rate settings. The same holds for the partial clearing that keeps the low prescaler bits, the effect of stop on the prescaler, and a rate change in mid-count. The bench checks these against a cycle model of the combined count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF;

    // Action applied to the count in one cycle, already ranked by priority
    typedef enum logic [2:0] {
        ACT_COUNT   = 3'd0,
        ACT_ZERO    = 3'd1,
        ACT_SERVICE = 3'd2,
        ACT_STOP    = 3'd3,
        ACT_FIRE    = 3'd4
    } wdt_act_e;

endpackage

// File: rtl/wdt_arbiter.sv
module wdt_arbiter
    import wdt_pkg::*;
(
    input  logic              busy_i,
    input  logic              test_hv_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              stop_i,
    input  logic              at_limit_i,
    output wdt_act_e          act_o
);

    logic svc_hit;

    // The data value never changes the outcome; any value services the timer.
    always_comb begin
        svc_hit = bus_wr_i && (bus_addr_i == SVC_ADDR) && (|{bus_data_i, 1'b1});
    end

    always_comb begin
        if (busy_i) begin
            act_o = ACT_ZERO;
        end else if (test_hv_i) begin
            act_o = ACT_ZERO;
        end else if (svc_hit) begin
            act_o = ACT_SERVICE;
        end else if (stop_i) begin
            act_o = ACT_STOP;
        end else if (at_limit_i) begin
            act_o = ACT_FIRE;
        end else begin
            act_o = ACT_COUNT;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W   = 12,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned SHORT_W = 13,
    parameter int unsigned KEEP_W  = 4
) (
    input  logic     clk_i,
    input  logic     por_n_i,
    input  wdt_act_e act_i,
    input  logic     rate_short_i,
    output logic     at_limit_o
);

    localparam int unsigned TOT_W = PRE_W + CNT_W;
    localparam logic [PRE_W-1:0] KEEP_MASK =
        {{(PRE_W-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } cnt_state_t;

    cnt_state_t state_d;
    cnt_state_t state_q;
    logic [TOT_W-1:0] tot;
    logic             long_hit;
    logic             short_hit;

    always_comb begin
        tot       = state_q;
        long_hit  = &tot;
        short_hit = &tot[SHORT_W-1:0];
        at_limit_o = rate_short_i ? short_hit : long_hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (act_i)
            ACT_COUNT: begin
                state_d.pre = state_q.pre + 1'b1;
                if (&state_q.pre) begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            ACT_SERVICE: begin
                state_d.cnt = '0;
                state_d.pre = state_q.pre & KEEP_MASK;
            end
            ACT_STOP: begin
                state_d.pre = '0;
            end
            ACT_ZERO, ACT_FIRE: begin
                state_d = '0;
            end
            default: begin
                state_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_LEN = 32
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic start_i,
    output logic busy_o,
    output logic rst_n_o
);

    localparam int unsigned PW = $clog2(PULSE_LEN) + 1;
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] left;
    } pulse_state_t;

    pulse_state_t state_d;
    pulse_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.busy) begin
            if (state_q.left == '0) begin
                state_d.busy = 1'b0;
            end else begin
                state_d.left = state_q.left - 1'b1;
            end
        end else if (start_i) begin
            state_d.busy = 1'b1;
            state_d.left = LOAD;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o  = state_q.busy;
    assign rst_n_o = ~state_q.busy;

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W     = 12,
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned SHORT_W   = 13,
    parameter int unsigned KEEP_W    = 4,
    parameter int unsigned PULSE_LEN = 32
) (
    input  logic              clk_i,
    input  logic              por_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic              rate_short_i,
    input  logic              stop_i,
    input  logic              test_hv_i,
    input  logic              flag_clr_i,
    output logic              rst_n_o,
    output logic              wdt_flag_o
);

    wdt_act_e act;
    logic     at_limit;
    logic     busy;
    logic     fire;

    assign fire = (act == ACT_FIRE);

    wdt_arbiter u_arb (
        .busy_i     (busy),
        .test_hv_i  (test_hv_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_data_i (bus_data_i),
        .stop_i     (stop_i),
        .at_limit_i (at_limit),
        .act_o      (act)
    );

    wdt_counter #(
        .PRE_W   (PRE_W),
        .CNT_W   (CNT_W),
        .SHORT_W (SHORT_W),
        .KEEP_W  (KEEP_W)
    ) u_cnt (
        .clk_i        (clk_i),
        .por_n_i      (por_n_i),
        .act_i        (act),
        .rate_short_i (rate_short_i),
        .at_limit_o   (at_limit)
    );

    wdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .start_i (fire),
        .busy_o  (busy),
        .rst_n_o (rst_n_o)
    );

    wdt_flag u_flag (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .set_i   (fire),
        .clr_i   (flag_clr_i),
        .flag_o  (wdt_flag_o)
    );

endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
    parameter int unsigned PULSE_LEN = 32
) (
    input logic        clk_i,
    input logic        por_n_i,
    input logic [15:0] bus_addr_i,
    input logic        bus_wr_i,
    input logic        test_hv_i,
    input logic        flag_clr_i,
    input logic        rst_n_o,
    input logic        wdt_flag_o
);

    localparam int unsigned LW = $clog2(PULSE_LEN + 1) + 2;

    logic [LW-1:0] low_cnt_q;

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            low_cnt_q <= '0;
        end else if (!rst_n_o) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end else begin
            low_cnt_q <= '0;
        end
    end

    // R5: each low pulse ends after exactly PULSE_LEN cycles
    assert_pulse_len_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(rst_n_o) |-> (low_cnt_q == LW'(PULSE_LEN)));

    // R5: the pulse never runs longer than PULSE_LEN
    assert_pulse_bound_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (low_cnt_q <= LW'(PULSE_LEN)));

    // R6: the flag is set when the pulse begins
    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rst_n_o) |-> wdt_flag_o);

    // R7: without a clear strobe the flag does not drop
    assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (wdt_flag_o && !flag_clr_i) |=> wdt_flag_o);

    // R9: test voltage keeps the reset output high
    assert_hv_quiet_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (test_hv_i && rst_n_o) |=> rst_n_o);

    // R11: a service write beats an overflow in the same cycle
    assert_svc_wins_R11: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (bus_wr_i && (bus_addr_i == 16'hFFFF) && rst_n_o) |=> rst_n_o);

endmodule

bind cop_watchdog cop_watchdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_i      (clk_i),
    .por_n_i    (por_n_i),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .test_hv_i  (test_hv_i),
    .flag_clr_i (flag_clr_i),
    .rst_n_o    (rst_n_o),
    .wdt_flag_o (wdt_flag_o)
);

// File: tb/cop_watchdog_tb.sv
`timescale 1ns/1ps
module cop_watchdog_tb;

    localparam int PRE_W     = 6;
    localparam int CNT_W     = 3;
    localparam int SHORT_W   = 6;
    localparam int KEEP_W    = 4;
    localparam int PULSE_LEN = 32;
    localparam int TOT_W     = PRE_W + CNT_W;
    localparam int LONG_LIM  = (1 << TOT_W) - 1;
    localparam int SHORT_LIM = (1 << SHORT_W) - 1;
    localparam int PRE_MASK  = (1 << PRE_W) - 1;
    localparam int KEEP_MASK = (1 << KEEP_W) - 1;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_data = 8'h00;
    logic        rate_short = 1'b0;
    logic        stop = 1'b0;
    logic        test_hv = 1'b0;
    logic        flag_clr = 1'b0;
    logic        rst_n;
    logic        wdt_flag;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // bench model state
    int m_tot = 0;
    int m_left = 0;
    bit m_flag = 0;

    always #2.5 clk = ~clk;

    cop_watchdog #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .SHORT_W(SHORT_W),
        .KEEP_W(KEEP_W), .PULSE_LEN(PULSE_LEN)
    ) u_dut (
        .clk_i(clk), .por_n_i(por_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
        .bus_data_i(bus_data), .rate_short_i(rate_short), .stop_i(stop),
        .test_hv_i(test_hv), .flag_clr_i(flag_clr), .rst_n_o(rst_n),
        .wdt_flag_o(wdt_flag)
    );

    function automatic bit at_limit(int tot, bit short_sel);
        if (short_sel) return (tot & SHORT_LIM) == SHORT_LIM;
        return tot == LONG_LIM;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b (cycle %0d)", tag, got, exp, cycles);
        end
    endtask

    task automatic model_step();
        bit svc;
        bit fire;
        svc  = bus_wr && (bus_addr == 16'hFFFF);
        fire = 0;
        if (m_left > 0) begin
            m_left--;
            m_tot = 0;
        end else if (test_hv) begin
            m_tot = 0;
        end else if (svc) begin
            m_tot = m_tot & KEEP_MASK;
        end else if (stop) begin
            m_tot = m_tot & ~PRE_MASK;
        end else if (at_limit(m_tot, rate_short)) begin
            fire = 1;
            m_tot = 0;
            m_left = PULSE_LEN;
        end else begin
            m_tot = m_tot + 1;
        end
        if (fire) m_flag = 1;
        else if (flag_clr) m_flag = 0;
    endtask

    // one clock: inputs already driven; compare after the edge
    task automatic step(string tag);
        @(posedge clk);
        cycles++;
        model_step();
        #1;
        check({tag, " rst_n_o"}, rst_n, (m_left == 0));
        check({tag, " wdt_flag_o"}, wdt_flag, m_flag);
    endtask

    task automatic idle();
        bus_wr = 0; bus_addr = 16'h0000; stop = 0; test_hv = 0; flag_clr = 0;
    endtask

    task automatic do_por();
        @(negedge clk);
        por_n = 0;
        idle();
        m_tot = 0; m_left = 0; m_flag = 0;
        #1;
        check("R1 reset rst_n_o", rst_n, 1'b1);
        check("R1 reset wdt_flag_o", wdt_flag, 1'b0);
        @(negedge clk);
        por_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int first_low;
        void'($urandom(32'h5EED_1234));
        do_por();
        step("R1 first cycle");

        // R2: long timeout from zero, exactly 2^TOT_W edges
        first_low = -1;
        for (int i = 2; i <= LONG_LIM + 2; i++) begin
            step("R2 long count");
            if (!rst_n && first_low < 0) first_low = i;
        end
        checks++;
        if (first_low != LONG_LIM + 1) begin
            errors++;
            $display("FAIL R2 first low edge: got %0d expected %0d", first_low, LONG_LIM + 1);
        end
        // R5/R10: pulse length with service writes during the pulse
        for (int i = 0; i < PULSE_LEN + 4; i++) begin
            bus_wr = (i % 3 == 0); bus_addr = 16'hFFFF;
            step("R5 R10 pulse");
        end
        idle();
        // R6/R7: flag sticky, then clear strobe
        for (int i = 0; i < 5; i++) step("R7 sticky");
        flag_clr = 1; step("R7 clear"); flag_clr = 0;
        check("R7 cleared", wdt_flag, 1'b0);

        // R4: service with varied data keeps it alive; other addresses do not
        do_por();
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < LONG_LIM - 40; i++) step("R4 run");
            bus_wr = 1; bus_addr = 16'hFFFF; bus_data = 8'($urandom);
            step("R4 service"); idle();
        end
        for (int i = 0; i < LONG_LIM; i++) begin
            bus_wr = (i % 4 == 0); bus_addr = 16'hFFFE; bus_data = 8'($urandom);
            step("R4 wrong address");
        end
        idle();
        for (int i = 0; i < 40; i++) step("R4 timeout");

        // R11: service in the overflow cycle
        do_por();
        for (int i = 0; i < LONG_LIM; i++) step("R11 approach");
        bus_wr = 1; bus_addr = 16'hFFFF; step("R11 svc at limit"); idle();
        check("R11 no reset", rst_n, 1'b1);
        for (int i = 0; i < 20; i++) step("R11 after");

        // R3: short mode, then change mid-count
        do_por();
        rate_short = 1;
        for (int i = 0; i < SHORT_LIM + PULSE_LEN + 10; i++) step("R3 short");
        rate_short = 0;
        for (int i = 0; i < 100; i++) step("R3 long mid");
        rate_short = 1;
        for (int i = 0; i < 80; i++) step("R3 switch");
        rate_short = 0;

        // R8: stop clears prescaler only
        do_por();
        for (int i = 0; i < 300; i++) step("R8 run");
        stop = 1; step("R8 stop"); stop = 0;
        for (int i = 0; i < 300; i++) step("R8 after");

        // R9: test voltage holds off the reset
        do_por();
        test_hv = 1;
        for (int i = 0; i < LONG_LIM + 50; i++) step("R9 hv");
        test_hv = 0;
        for (int i = 0; i < 20; i++) step("R9 release");

        // R7: flag survives other activity, clears on power-on reset
        rate_short = 1;
        for (int i = 0; i < SHORT_LIM + 5; i++) step("R6 set");
        rate_short = 0;
        do_por();
        step("R7 por cleared");

        // random mix of all inputs
        for (int i = 0; i < 12000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            bus_wr   = (r < 12);
            bus_addr = ($urandom_range(0, 3) == 0) ? 16'hFFFE : 16'hFFFF;
            bus_data = 8'($urandom);
            stop     = (r >= 12 && r < 20);
            flag_clr = (r >= 20 && r < 35);
            if ($urandom_range(0, 199) == 0) test_hv = ~test_hv;
            if ($urandom_range(0, 299) == 0) rate_short = ~rate_short;
            step("R11 random mix");
        end
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule